// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves received frames from a byte stream into host memory by way of a ring of descriptors. Each descriptor is a pair of 32-bit words in a word-addressed memory. The first word holds the byte address of a receive buffer. The second word holds an ownership flag, the status flags and the buffer size in bytes. At the start of a frame the engine reads the current descriptor. If the engine owns it, the engine loads the buffer address and stores the frame bytes one at a time, each with a single byte lane enabled. When a buffer fills before the frame ends, the engine reads the next descriptor. If that descriptor is also owned by the engine, the current one is closed and the frame continues in the new buffer.

When the frame ends, or when chaining fails, the engine writes back the status word of the descriptor it is filling. This write clears the ownership flag and sets the start, end and error flags. Each error flag follows its own rule for when it may be reported. A missing next buffer is not reported at once. The engine keeps the descriptor open and discards the rest of the frame. When the frame ends, it reports the buffer error together with an overflow, but only if the stream also signals an overflow on that last beat.

If the descriptor is host-owned when a frame starts, the engine writes nothing. It drops the whole frame, pulses a missed-frame output and stays on the same ring entry.

Top module: `rx_ring_writer`

## Requirements
- R1: Descriptor i sits at word addresses ring_base+2i (buffer byte address) and ring_base+2i+1 (status word). Frame byte k of a buffer goes to word address (buf+k)>>2 with only byte lane (buf+k)%4 enabled in mem_be. The read port has a one-cycle latency, and the engine never reads and writes in the same cycle.
- R2: A status write-back uses mem_be=4'hF and writes bit 31 (ownership) as 0. Bits 22:0, including the 16-bit size field in bits 15:0, keep the values fetched from the descriptor. A descriptor whose ownership bit reads 1 is never written while its buffer is still in use.
- R3: Status bit 30 (error summary) equals the OR of bits 29, 28, 27, 26 and 23.
- R4: Bit 29 (short-bit framing error) is set only on the end-of-frame descriptor, and only when the frame ends with both in_odd_bits and in_fcs_bad set, no overflow and loopback low.
- R5: If in_fifo_ovf is set on the last beat, the final descriptor gets bit 28 (overflow) set and bits 24, 27 and 29 clear.
- R6: Bit 27 (checksum error) is set on the final descriptor when in_fcs_bad is set on the last beat and no overflow is signalled. It is set nowhere else.
- R7: Bit 25 marks the first descriptor of a frame and bit 24 the last. A frame of L bytes with buffer size S fills ceil(L/S) consecutive descriptors, and every descriptor except the last is filled to exactly S bytes.
- R8: If the next descriptor is host-owned when a buffer fills mid-frame, the current descriptor is closed when the frame ends. It gets bit 26 (buffer error) set, bit 24 clear, and bit 28 equal to in_fifo_ovf on the last beat. The remaining bytes are discarded, and the next descriptor is not written.
- R9: Bit 23 (bus parity error) is set only when par_chk_en is high and in_bus_perr was seen on a stored byte of the frame. It appears only on a descriptor that has bit 24, 28 or 26 set.
- R10: A host-owned descriptor at the start of a frame causes a one-cycle missed_frame pulse. The frame is consumed without any memory write, and the next frame uses the same ring entry.
- R11: After each closed descriptor the ring index advances by one and wraps from 2**RING_LOG2-1 to 0.
- R12: When lookahead_mode is high, bit 25 keeps the value the host wrote instead of being written by the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | AW | Word address of descriptor 0 |
| loopback | input | 1 | Internal loopback; suppresses the framing error |
| par_chk_en | input | 1 | Enables bus parity error reporting |
| lookahead_mode | input | 1 | Host owns the start-of-frame flag |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Engine accepts the byte |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of the frame |
| in_fcs_bad | input | 1 | Checksum failed (valid with in_last) |
| in_odd_bits | input | 1 | Bit count not a multiple of 8 (valid with in_last) |
| in_fifo_ovf | input | 1 | Receive FIFO overflowed (valid with in_last) |
| in_bus_perr | input | 1 | Parity error on this byte's transfer |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | AW | Word address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid one cycle after mem_rd |
| missed_frame | output | 1 | One-cycle pulse for a dropped frame |

## Verification
The sweep crosses buffer sizes 1 to 4 with every frame length that fits in the ring. This catches an off-by-one in the fill count: such a design would chain one byte too early or too late, and the start and end flags would land on the wrong entries. A second sweep covers all combinations of the end-of-frame flags, loopback and parity enable. It targets a design that reports a framing error without a checksum error, reports checksum errors next to an overflow, or lets a parity error through while the enable is off. The buffer-error cases check that the overflow is reported only when it coincides with the buffer error, and that the host-owned neighbour is left untouched. The missed-frame case checks that a design which advanced the ring index anyway would send the following frame to the wrong entry.

// File: rtl/rx_ring_writer.sv
module rx_ring_writer #(
  parameter int AW       = 16,
  parameter int RING_LOG2 = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          loopback,
  input  logic          par_chk_en,
  input  logic          lookahead_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_fcs_bad,
  input  logic          in_odd_bits,
  input  logic          in_fifo_ovf,
  input  logic          in_bus_perr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          missed_frame
);

  localparam int PW = AW + 2;

  typedef enum logic [3:0] {
    S_IDLE, S_RDST, S_CKST, S_RDAD, S_LDAD, S_DATA,
    S_CHRD, S_CHCK, S_CLOSE, S_DROP, S_BDROP
  } state_t;

  state_t               st;
  logic [RING_LOG2-1:0] idx;
  logic [RING_LOG2-1:0] nidx;
  logic [22:0]          cur_lo, nxt_lo;
  logic                 cur_stp, nxt_stp;
  logic [PW-1:0]        ptr;
  logic [15:0]          cnt;
  logic                 first, perr, cont;
  logic                 f_enp, f_ofl, f_crc, f_frm, f_buf, f_bpe;
  logic [AW-1:0]        cur_desc, nxt_desc;
  logic [31:0]          wb_word;
  logic                 wb_stp, wb_err;
  logic                 take;
  logic                 unused_bits;

  assign nidx     = idx + 1'b1;
  assign cur_desc = ring_base + AW'({idx, 1'b0});
  assign nxt_desc = ring_base + AW'({nidx, 1'b0});
  assign take     = in_valid && in_ready;
  assign unused_bits = ^{mem_rdata[30:26], mem_rdata[24:23]};

  assign wb_stp  = lookahead_mode ? cur_stp : first;
  assign wb_err  = f_frm | f_ofl | f_crc | f_buf | f_bpe;
  assign wb_word = {1'b0, wb_err, f_frm, f_ofl, f_crc, f_buf, wb_stp, f_enp, f_bpe, cur_lo};

  assign in_ready = (st == S_DATA) || (st == S_DROP) || (st == S_BDROP);
  assign mem_rd   = (st == S_RDST) || (st == S_RDAD) || (st == S_CHRD);
  assign mem_wr   = (st == S_CLOSE) || (st == S_DATA && in_valid);
  assign mem_be   = (st == S_CLOSE) ? 4'hF : (4'b0001 << ptr[1:0]);
  assign mem_wdata = (st == S_CLOSE) ? wb_word : {4{in_data}};

  always_comb begin
    case (st)
      S_RDST, S_CLOSE: mem_addr = cur_desc + AW'(1);
      S_RDAD:          mem_addr = cur_desc;
      S_CHRD:          mem_addr = nxt_desc + AW'(1);
      S_DATA:          mem_addr = ptr[PW-1:2];
      default:         mem_addr = cur_desc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      cur_lo <= '0;
      nxt_lo <= '0;
      cur_stp <= 1'b0;
      nxt_stp <= 1'b0;
      ptr <= '0;
      cnt <= '0;
      first <= 1'b1;
      perr <= 1'b0;
      cont <= 1'b0;
      {f_enp, f_ofl, f_crc, f_frm, f_buf, f_bpe} <= '0;
      missed_frame <= 1'b0;
    end else begin
      missed_frame <= 1'b0;
      case (st)
        S_IDLE: begin
          first <= 1'b1;
          perr  <= 1'b0;
          if (in_valid) st <= S_RDST;
        end
        S_RDST: st <= S_CKST;
        S_CKST: begin
          cur_lo  <= mem_rdata[22:0];
          cur_stp <= mem_rdata[25];
          if (mem_rdata[31]) st <= S_RDAD;
          else begin
            missed_frame <= 1'b1;
            st <= S_DROP;
          end
        end
        S_RDAD: st <= S_LDAD;
        S_LDAD: begin
          ptr <= mem_rdata[PW-1:0];
          cnt <= '0;
          st  <= S_DATA;
        end
        S_DATA: if (take) begin
          ptr  <= ptr + 1'b1;
          cnt  <= cnt + 16'd1;
          perr <= perr | in_bus_perr;
          if (in_last) begin
            f_enp <= !in_fifo_ovf;
            f_ofl <= in_fifo_ovf;
            f_crc <= in_fcs_bad && !in_fifo_ovf;
            f_frm <= in_fcs_bad && in_odd_bits && !in_fifo_ovf && !loopback;
            f_buf <= 1'b0;
            f_bpe <= par_chk_en && (perr || in_bus_perr);
            cont  <= 1'b0;
            st    <= S_CLOSE;
          end else if (cnt + 16'd1 == cur_lo[15:0]) begin
            st <= S_CHRD;
          end
        end
        S_CHRD: st <= S_CHCK;
        S_CHCK: begin
          if (mem_rdata[31]) begin
            nxt_lo  <= mem_rdata[22:0];
            nxt_stp <= mem_rdata[25];
            {f_enp, f_ofl, f_crc, f_frm, f_buf, f_bpe} <= '0;
            cont <= 1'b1;
            st   <= S_CLOSE;
          end else begin
            st <= S_BDROP;
          end
        end
        S_BDROP: if (take && in_last) begin
          f_enp <= 1'b0;
          f_ofl <= in_fifo_ovf;
          f_crc <= 1'b0;
          f_frm <= 1'b0;
          f_buf <= 1'b1;
          f_bpe <= par_chk_en && perr;
          cont  <= 1'b0;
          st    <= S_CLOSE;
        end
        S_CLOSE: begin
          idx <= nidx;
          if (cont) begin
            cur_lo  <= nxt_lo;
            cur_stp <= nxt_stp;
            first   <= 1'b0;
            st      <= S_RDAD;
          end else begin
            st <= S_IDLE;
          end
        end
        S_DROP: if (take && in_last) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loopback,
  input logic          par_chk_en,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          missed_frame
);

  logic wbk;
  logic [8:0] s;
  logic unused_a;
  assign wbk = mem_wr && (mem_be == 4'hF);
  assign s   = mem_wdata[31:23];
  assign unused_a = ^{mem_addr, mem_wdata[22:0]};

  // R1
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R1
  lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !wbk) |-> ($countones(mem_be) == 1));

  // R2
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbk |-> !s[8]);

  // R3
  err_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbk |-> (s[7] == (s[6] | s[5] | s[4] | s[3] | s[0])));

  // R4
  fram_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbk && s[6]) |-> (s[1] && !s[5] && s[4] && !loopback));

  // R5
  oflo_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbk && s[5]) |-> !s[1]);

  // R6
  crc_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbk && s[4]) |-> (s[1] && !s[5]));

  // R9
  bpe_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wbk && s[0]) |-> (par_chk_en && (s[1] || s[5] || s[3])));

  // R10
  missed_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    missed_frame |=> !missed_frame);

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .loopback(loopback), .par_chk_en(par_chk_en),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .missed_frame(missed_frame)
);

// File: tb/rx_ring_writer_tb.sv
module rx_ring_writer_tb;
  localparam int AW = 10;
  localparam int RL2 = 2;
  localparam int ND = 4;
  localparam logic [AW-1:0] RBASE = 10'h040;

  logic clk = 0, rst_n = 0;
  logic loopback = 0, par_chk_en = 0, lookahead_mode = 0;
  logic in_valid = 0, in_last = 0, in_fcs_bad = 0, in_odd_bits = 0, in_fifo_ovf = 0, in_bus_perr = 0;
  logic [7:0] in_data = 0;
  logic in_ready, mem_rd, mem_wr, missed_frame;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] mem [0:(1<<AW)-1];
  logic hw = 0;
  logic [AW-1:0] ha = 0;
  logic [31:0] hd = 0;

  int nchk = 0, nfail = 0, miss_cnt = 0, exp_idx = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_ring_writer #(.AW(AW), .RING_LOG2(RL2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(RBASE), .loopback(loopback),
    .par_chk_en(par_chk_en), .lookahead_mode(lookahead_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_fcs_bad(in_fcs_bad), .in_odd_bits(in_odd_bits), .in_fifo_ovf(in_fifo_ovf),
    .in_bus_perr(in_bus_perr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .missed_frame(missed_frame)
  );

  always @(posedge clk) begin
    if (hw) mem[ha] <= hd;
    if (mem_wr)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (missed_frame) miss_cnt <= miss_cnt + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic hwrite(input int a, input logic [31:0] d);
    @(negedge clk); hw = 1; ha = AW'(a); hd = d;
    @(negedge clk); hw = 0;
  endtask

  function automatic int dword(input int d); return int'(RBASE) + 2*d; endfunction
  function automatic logic [31:0] bufadr(input int d); return 32'h800 + 32'(d*32); endfunction

  function automatic logic [31:0] w1(input bit own, input bit stp, input int sz);
    return {own, 5'b0, stp, 1'b0, 8'h00, 16'(sz)};
  endfunction

  function automatic logic [31:0] stat(input bit frm, ofl, crc, bf, stp, enp, bpe, input int sz);
    return {1'b0, (frm|ofl|crc|bf|bpe), frm, ofl, crc, bf, stp, enp, bpe, 7'b0, 16'(sz)};
  endfunction

  function automatic logic [7:0] dat(input int tag, input int j);
    return 8'(tag*13 + j*7 + 1);
  endfunction

  function automatic logic [7:0] membyte(input int d, input int off);
    logic [31:0] w;
    w = mem[AW'(32'h200 + d*8 + off/4)];
    return w[8*(off%4) +: 8];
  endfunction

  task automatic init_ring(input int sz, input logic [3:0] own, input logic [3:0] stp);
    for (int d = 0; d < ND; d++) begin
      hwrite(dword(d), bufadr(d));
      hwrite(dword(d)+1, w1(own[d], stp[d], sz));
      for (int w = 0; w < 8; w++) hwrite(32'h200 + d*8 + w, 32'h0);
    end
  endtask

  task automatic send_frame(input int len, input int tag, input bit fcs, input bit odd,
                            input bit ovf, input int perr_at);
    for (int j = 0; j < len; j++) begin
      @(negedge clk);
      in_valid = 1; in_data = dat(tag, j);
      in_last = (j == len-1);
      in_fcs_bad = (j == len-1) && fcs;
      in_odd_bits = (j == len-1) && odd;
      in_fifo_ovf = (j == len-1) && ovf;
      in_bus_perr = (j == perr_at);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_fcs_bad = 0; in_odd_bits = 0; in_fifo_ovf = 0; in_bus_perr = 0;
    repeat (8) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", nchk, 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n, d, m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rd", 32'(mem_rd), 0);
    chk("R1 reset wr", 32'(mem_wr), 0);
    chk("R10 reset missed", 32'(missed_frame), 0);
    chk("R1 reset ready", 32'(in_ready), 0);
    rst_n = 1;

    // R7 R1 R11: size x length sweep, clean frames, ring wraps repeatedly
    for (int sz = 1; sz <= 4; sz++) begin
      for (int len = 1; len <= 4*sz; len++) begin
        init_ring(sz, 4'hF, 4'h0);
        send_frame(len, sz*17 + len, 0, 0, 0, -1);
        n = (len + sz - 1) / sz;
        for (int k = 0; k < n; k++) begin
          d = (exp_idx + k) % ND;
          chk($sformatf("R7 status s=%0d l=%0d k=%0d", sz, len, k), mem[AW'(dword(d)+1)],
              stat(0, 0, 0, 0, k == 0, k == n-1, 0, sz));
        end
        if (n < ND) begin
          d = (exp_idx + n) % ND;
          chk($sformatf("R11 untouched s=%0d l=%0d", sz, len), mem[AW'(dword(d)+1)], w1(1, 0, sz));
        end
        for (int j = 0; j < len; j++) begin
          d = (exp_idx + j/sz) % ND;
          chk($sformatf("R1 byte s=%0d l=%0d j=%0d", sz, len, j), 32'(membyte(d, j%sz)),
              32'(dat(sz*17 + len, j)));
        end
        exp_idx = (exp_idx + n) % ND;
      end
    end

    // R3 R4 R5 R6 R9: all end-of-frame flag combinations, single buffer
    for (int f = 0; f < 64; f++) begin
      bit fcs, odd, ovf, pe, lb, pen;
      fcs = f[0]; odd = f[1]; ovf = f[2]; pe = f[3]; lb = f[4]; pen = f[5];
      loopback = lb; par_chk_en = pen;
      init_ring(8, 4'hF, 4'h0);
      send_frame(3, f, fcs, odd, ovf, pe ? 1 : -1);
      chk($sformatf("R4 R5 R6 R9 flags f=%0d", f), mem[AW'(dword(exp_idx)+1)],
          stat(fcs && odd && !ovf && !lb, ovf, fcs && !ovf, 0, 1, !ovf, pen && pe, 8));
      exp_idx = (exp_idx + 1) % ND;
    end
    loopback = 0;

    // R6 R4 R5 R9: multi-buffer frame, errors only on final descriptor
    for (int ov = 0; ov < 2; ov++) begin
      par_chk_en = 1;
      init_ring(2, 4'hF, 4'h0);
      send_frame(5, 90 + ov, 1, 1, ov[0], 0);
      for (int k = 0; k < 3; k++) begin
        d = (exp_idx + k) % ND;
        if (k < 2)
          chk($sformatf("R6 mid clean ov=%0d k=%0d", ov, k), mem[AW'(dword(d)+1)],
              stat(0, 0, 0, 0, k == 0, 0, 0, 2));
        else
          chk($sformatf("R5 R6 last ov=%0d", ov), mem[AW'(dword(d)+1)],
              stat(!ov[0], ov[0], !ov[0], 0, 0, !ov[0], 1, 2));
      end
      exp_idx = (exp_idx + 3) % ND;
    end

    // R8: next buffer host-owned, overflow reported only alongside it
    for (int ov = 0; ov < 2; ov++) begin
      logic [3:0] om;
      par_chk_en = 1;
      om = 4'(1 << exp_idx);
      init_ring(2, om, 4'h0);
      send_frame(5, 100 + ov, 1, 0, ov[0], 0);
      chk($sformatf("R8 buff status ov=%0d", ov), mem[AW'(dword(exp_idx)+1)],
          stat(0, ov[0], 0, 1, 1, 0, 1, 2));
      d = (exp_idx + 1) % ND;
      chk($sformatf("R8 next untouched ov=%0d", ov), mem[AW'(dword(d)+1)], w1(0, 0, 2));
      chk($sformatf("R8 next buffer empty ov=%0d", ov), mem[AW'(32'h200 + d*8)], 0);
      chk($sformatf("R8 stored byte ov=%0d", ov), 32'(membyte(exp_idx, 1)), 32'(dat(100 + ov, 1)));
      exp_idx = (exp_idx + 1) % ND;
    end
    par_chk_en = 0;

    // R9: parity error with checking disabled stays hidden on a buffer error
    init_ring(2, 4'(1 << exp_idx), 4'h0);
    send_frame(4, 120, 0, 0, 0, 0);
    chk("R9 disabled on buff", mem[AW'(dword(exp_idx)+1)], stat(0, 0, 0, 1, 1, 0, 0, 2));
    exp_idx = (exp_idx + 1) % ND;

    // R10: missed frame, same entry used next
    init_ring(4, 4'h0, 4'h0);
    m = miss_cnt;
    send_frame(3, 130, 0, 0, 0, -1);
    chk("R10 missed pulse count", 32'(miss_cnt - m), 1);
    chk("R10 desc untouched", mem[AW'(dword(exp_idx)+1)], w1(0, 0, 4));
    chk("R10 buffer untouched", mem[AW'(32'h200 + exp_idx*8)], 0);
    init_ring(4, 4'hF, 4'h0);
    send_frame(1, 131, 0, 0, 0, -1);
    chk("R10 R11 same entry reused", mem[AW'(dword(exp_idx)+1)], stat(0, 0, 0, 0, 1, 1, 0, 4));
    chk("R10 byte lands", 32'(membyte(exp_idx, 0)), 32'(dat(131, 0)));
    exp_idx = (exp_idx + 1) % ND;

    // R12: lookahead mode keeps the host's start flag
    lookahead_mode = 1;
    init_ring(2, 4'hF, 4'(1 << ((exp_idx + 1) % ND)));
    send_frame(4, 140, 0, 0, 0, -1);
    chk("R12 first keeps host 0", mem[AW'(dword(exp_idx)+1)], stat(0, 0, 0, 0, 0, 0, 0, 2));
    d = (exp_idx + 1) % ND;
    chk("R12 second keeps host 1", mem[AW'(dword(d)+1)], stat(0, 0, 0, 0, 1, 1, 0, 2));
    lookahead_mode = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule